// File: doc/BRIEF.md
# Sequential Radix-4 Multiply-Accumulate Unit

This unit multiplies two W-bit operands and can add a third operand to the product. It keeps only the low W bits of the result. A one-cycle `start` pulse, accepted only while the unit is idle, captures the multiplicand, the multiplier and the optional addend. One setup cycle follows, then one cycle for each two-bit group of the multiplier, recoded with radix-4 Booth steps. The sequence ends as soon as the multiplier bits that remain would add no further partial products.

The finished result comes with a one-cycle `done` pulse. At the same time the unit reports how many cycles the operation used. If the caller asked for flag updates, it also reports a negative flag and a zero flag. A caller such as a processor execute stage uses the cycle count to schedule around the data-dependent latency.

Top module: `booth_mac_seq`

## Requirements
- R1: When `done` is high, `result` equals the low W bits of `op_a*op_b`, plus `addend` when `acc_en` was high at start. The value is the same whether the operands are read as signed or unsigned.
- R2: `cycles` on completion equals 1+G. G is the smallest k≥1 such that multiplier bits [W-1 : 2k-1] are all equal. G is 0 when the multiplier is zero.
- R3: A zero multiplier completes after the setup cycle alone, so `cycles` is 1.
- R4: Accumulation adds no cycles: the same multiplier gives the same `cycles` with `acc_en` high or low.
- R5: `done` is high for exactly one cycle per operation. `busy` is high from the edge that accepts `start` until the final edge, and is low while `done` is high.
- R6: A `start` pulse while `busy` is high is ignored. The running operation finishes with its own result and cycle count.
- R7: When `set_flags` was high at start, `flag_n` becomes result bit W-1 and `flag_z` becomes 1 exactly when the result is zero. Otherwise both flags keep their previous values.
- R8: After reset, `busy`, `done`, `result`, `cycles`, `flag_n` and `flag_z` are all 0.
- R9: No operation takes more than 1+W/2 cycles. A multiplier whose top two bits differ takes exactly that many.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| op_a | input | W | Multiplicand |
| op_b | input | W | Multiplier (Booth-recoded) |
| addend | input | W | Value added to the product when acc_en is set |
| acc_en | input | 1 | Select multiply-accumulate |
| set_flags | input | 1 | Update flag_n and flag_z on completion |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | W | Low W bits of the product (plus addend) |
| cycles | output | CW | Cycles used by the last operation |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |

## Verification
The hardest condition to reach is termination at each possible group position. Uniform random multipliers almost always end after the full sixteen groups. The stimulus therefore shifts random values arithmetically right by a random amount, so the run of sign bits starts at every group boundary, for both positive and negative multipliers. Directed cases add zero, minus one, and values whose top two bits differ. A separate case pulses `start` in the middle of a long operation.

// File: rtl/booth_mac_seq.sv
module booth_mac_seq #(
  parameter int W  = 32,
  parameter int CW = $clog2(W/2 + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  op_a,
  input  logic [W-1:0]  op_b,
  input  logic [W-1:0]  addend,
  input  logic          acc_en,
  input  logic          set_flags,
  output logic          busy,
  output logic          done,
  output logic [W-1:0]  result,
  output logic [CW-1:0] cycles,
  output logic          flag_n,
  output logic          flag_z
);

  typedef enum logic [1:0] {IDLE, SETUP, RUN} st_t;
  localparam int MAXC = W/2 + 1;

  st_t           state;
  logic [W-1:0]  mc, mp, acc, pp;
  logic          prev, fl_q;
  logic [CW-1:0] cyc;
  logic [W-1:0]  mp_nx, acc_nx;
  logic          last;

  always_comb begin
    case ({mp[1:0], prev})
      3'b001, 3'b010: pp = mc;
      3'b011:         pp = mc << 1;
      3'b100:         pp = -(mc << 1);
      3'b101, 3'b110: pp = -mc;
      default:        pp = '0;
    endcase
  end

  assign mp_nx  = W'($signed(mp) >>> 2);
  assign acc_nx = acc + pp;
  assign last   = (mp_nx == {W{mp[1]}});
  assign busy   = (state != IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= IDLE;
      mc     <= '0;
      mp     <= '0;
      acc    <= '0;
      prev   <= 1'b0;
      fl_q   <= 1'b0;
      cyc    <= '0;
      done   <= 1'b0;
      result <= '0;
      cycles <= '0;
      flag_n <= 1'b0;
      flag_z <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        IDLE: if (start) begin
          mc    <= op_a;
          mp    <= op_b;
          prev  <= 1'b0;
          acc   <= acc_en ? addend : '0;
          fl_q  <= set_flags;
          cyc   <= CW'(1);
          state <= SETUP;
        end
        SETUP: if (mp == '0) begin
          done   <= 1'b1;
          result <= acc;
          cycles <= CW'(1);
          if (fl_q) begin
            flag_n <= acc[W-1];
            flag_z <= (acc == '0);
          end
          state <= IDLE;
        end else begin
          cyc   <= CW'(2);
          state <= RUN;
        end
        default: begin
          acc  <= acc_nx;
          mc   <= mc << 2;
          mp   <= mp_nx;
          prev <= mp[1];
          if (last) begin
            done   <= 1'b1;
            result <= acc_nx;
            cycles <= cyc;
            if (fl_q) begin
              flag_n <= acc_nx[W-1];
              flag_z <= (acc_nx == '0);
            end
            state <= IDLE;
          end else begin
            cyc <= cyc + 1'b1;
          end
        end
      endcase
    end
  end

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_zero_mult_fast_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SETUP && mp == '0) |=> (done && cycles == CW'(1)));

  assert_no_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RUN) |=> (state != SETUP));

  assert_cycle_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RUN) |-> (cyc <= CW'(MAXC)));

  assert_flags_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fl_q) |-> ($stable(flag_n) && $stable(flag_z)));

  assert_idle_result_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == IDLE) |=> $stable(result));

endmodule

// File: tb/tb_booth_mac_seq.sv
module tb_booth_mac_seq;
  localparam int W  = 32;
  localparam int CW = $clog2(W/2 + 2);

  logic clk = 0, rst_n = 0, start = 0, acc_en = 0, set_flags = 0;
  logic [W-1:0] op_a = '0, op_b = '0, addend = '0;
  logic busy, done, flag_n, flag_z;
  logic [W-1:0] result;
  logic [CW-1:0] cycles;
  int nchk = 0, nfail = 0;
  logic en_n = 0, en_z = 0;

  always #10 clk = ~clk;

  booth_mac_seq #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .addend(addend), .acc_en(acc_en), .set_flags(set_flags), .busy(busy),
    .done(done), .result(result), .cycles(cycles), .flag_n(flag_n), .flag_z(flag_z));

  function automatic int exp_groups(logic [W-1:0] b);
    if (b == '0) return 0;
    for (int k = 1; k <= W/2; k++) begin
      logic [W-1:0] t;
      t = W'($signed(b) >>> (2*k - 1));
      if (t == '0 || t == '1) return k;
    end
    return W/2;
  endfunction

  function automatic logic [W-1:0] exp_res(logic [W-1:0] a, logic [W-1:0] b,
                                           logic [W-1:0] c, logic en);
    logic [2*W-1:0] p;
    p = a * b;
    return p[W-1:0] + (en ? c : '0);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] expv);
    nchk++;
    if (act !== expv) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic run_op(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c,
                        logic en, logic fl, logic inject, output int lat);
    int n;
    logic busy_ok;
    logic [W-1:0] er;
    @(negedge clk);
    op_a = a; op_b = b; addend = c; acc_en = en; set_flags = fl; start = 1;
    @(negedge clk);
    start = 0;
    n = 1;
    busy_ok = 1;
    while (!done && n < 40) begin
      if (!busy) busy_ok = 0;
      if (inject && n == 2) begin
        op_a = ~a; op_b = 32'h0000_0003; addend = 32'h1234; acc_en = ~en; start = 1;
      end
      @(negedge clk);
      start = 0;
      n++;
    end
    if (n >= 40) begin
      nchk++; nfail++;
      $display("FAIL watchdog R5 actual=%0d expected<40", n);
    end
    er = exp_res(a, b, c, en);
    check(inject ? "R6 result" : "R1 result", result, er);
    check(inject ? "R6 cycles" : "R2 cycles", cycles, 1 + exp_groups(b));
    check("R2 latency", n, 2 + exp_groups(b));
    check("R5 busy during op", busy_ok, 1);
    check("R5 busy low at done", busy, 0);
    if (fl) begin en_n = er[W-1]; en_z = (er == '0); end
    check("R7 flag_n", flag_n, en_n);
    check("R7 flag_z", flag_z, en_z);
    @(negedge clk);
    check("R5 done one cycle", done, 0);
    lat = cycles;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int l1, l2;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R8 busy", busy, 0);
    check("R8 done", done, 0);
    check("R8 result", result, 0);
    check("R8 cycles", cycles, 0);
    check("R8 flags", {flag_n, flag_z}, 0);
    rst_n = 1;

    run_op(32'd18, '1, '0, 0, 1, 0, l1);
    check("R2 minus one", l1, 2);
    run_op(32'hDEAD_BEEF, '0, 32'h55, 1, 1, 0, l1);
    check("R3 zero mult", l1, 1);
    run_op(32'h7, '0, '0, 0, 1, 0, l1);
    check("R7 zero result flag", flag_z, 1);
    run_op(32'h1357_9BDF, 32'h8000_0001, '0, 0, 1, 0, l1);
    check("R9 worst case", l1, 1 + W/2);
    run_op(32'h0000_0005, 32'h4000_0000, 32'h10, 1, 0, 0, l1);
    check("R9 bound", l1, 1 + W/2);
    run_op(32'hFFFF_FFFB, 32'h0000_00FF, 32'hA, 0, 0, 0, l1);
    run_op(32'hFFFF_FFFB, 32'h0000_00FF, 32'hA, 1, 0, 0, l2);
    check("R4 acc free", l2, l1);
    run_op(32'h1234_5678, 32'h7FFF_0000, 32'h0F0F, 1, 1, 1, l1);
    run_op(32'h8000_0000, 32'h8000_0000, 32'hFFFF_FFFF, 1, 1, 0, l1);

    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] a, b, c;
      a = $urandom; c = $urandom;
      b = W'($signed($urandom) >>> ($urandom % 32));
      run_op(a, b, c, 1'($urandom), 1'($urandom), 0, l1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule